// File: doc/BRIEF.md
# Fast A20 Gate and Alternate CPU Reset Control

This block holds one small software-visible control byte for a PC-style system I/O controller. Software uses it to open the A20 address gate without going through the slow keyboard controller, and to restart the CPU quickly. One bit drives an alternate A20 gate. That gate is ORed with the keyboard controller's own gate to form the A20 mask output. A second bit starts a one-shot reset sequence. After a rising write of that bit, the active-low alternate reset output waits a fixed delay and then goes low for a fixed width.

The alternate reset is ANDed with the keyboard controller's active-low reset to form a combined CPU reset output. An enable input decides whether the alternate reset takes part in that combination. A polarity input selects whether the combined output is active-low or active-high.

Delay and width are given in microseconds together with the clock frequency in MHz, and the block converts them to clock cycles. The host address decoder and the keyboard controller are outside the block; their results arrive as plain inputs.

Top module: `fastgate_ctrl`

## Requirements
- R1: After reset, both control bits are 0, alt_rst_n_o is 1, and a read returns 8'h00.
- R2: A write with bus_sel=1 and bus_wr=1 stores bus_wdata[1] as the A20 gate bit and bus_wdata[0] as the reset-request bit.
- R3: While bus_sel=1 and bus_rd=1, bus_rdata = {6'b0, gate bit, reset-request bit}; at any other time bus_rdata is 8'h00. Bits [7:2] of a write have no effect.
- R4: A write with bus_sel=0 leaves both bits unchanged.
- R5: After the write edge that takes the reset-request bit from 0 to 1, alt_rst_n_o stays 1 for DELAY_US*CLK_MHZ cycles. It goes to 0 on the following edge (delay DELAY_US*CLK_MHZ + 1 edges, within one cycle of the nominal value).
- R6: alt_rst_n_o then stays 0 for exactly PULSE_US*CLK_MHZ cycles and returns to 1.
- R7: Writing 1 to the reset-request bit while it already holds 1 produces no further pulse.
- R8: Once the bit has been written back to 0, a new write of 1 starts a new delayed pulse.
- R9: a20_mask_o = kbc_gate_i OR gate bit; it is 0 only when both are 0.
- R10: The internal combined reset is low when kbc_rst_n_i is 0, or when alt_rst_n_o is 0 while rst_route_en_i is 1. While rst_route_en_i is 0, the alternate pulse does not reach cpu_rst_o.
- R11: cpu_rst_o carries the combined reset unchanged when rst_pol_i=0 (active-low) and inverted when rst_pol_i=1 (active-high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_sel | input | 1 | Register select from the host decoder |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| kbc_gate_i | input | 1 | A20 gate from the keyboard controller |
| kbc_rst_n_i | input | 1 | Active-low reset from the keyboard controller |
| rst_route_en_i | input | 1 | Lets the alternate reset reach cpu_rst_o |
| rst_pol_i | input | 1 | 0: cpu_rst_o active-low, 1: active-high |
| a20_mask_o | output | 1 | Combined A20 gate |
| alt_rst_n_o | output | 1 | Delayed active-low alternate reset pulse |
| cpu_rst_o | output | 1 | Combined CPU reset, selected polarity |

## Verification
The bench builds the block with CLK_MHZ=1, which keeps the defaults of 14 µs delay and 6 µs width. The timer then runs for 14 and 6 cycles instead of several hundred. This lets one run measure the exact delay and width of three separate pulses. It also leaves time for a long idle stretch after a repeated write of 1, where no pulse may appear. With the short timer, the bench can also exercise enable masking and both output polarities while a pulse is active.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_DELAY = 2'd1,
    TMR_PULSE = 2'd2,
    TMR_DONE  = 2'd3
  } tmr_state_e;

  localparam int unsigned REG_W = 8;
endpackage

// File: rtl/fg_ctrl_reg.sv
module fg_ctrl_reg
  import fg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       wdata_lo,
  output logic             gate_bit,
  output logic             req_bit,
  output logic [REG_W-1:0] rdata
);
  logic gate_d, req_d;
  logic wr_en;

  assign wr_en = sel & wr;

  always_comb begin
    gate_d = gate_bit;
    req_d  = req_bit;
    if (wr_en) begin
      gate_d = wdata_lo[1];
      req_d  = wdata_lo[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_bit <= 1'b0;
      req_bit  <= 1'b0;
    end else begin
      gate_bit <= gate_d;
      req_bit  <= req_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel && rd) rdata = {{(REG_W-2){1'b0}}, gate_bit, req_bit};
  end
endmodule

// File: rtl/fg_pulse_timer.sv
module fg_pulse_timer
  import fg_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 14,
  parameter int unsigned PULSE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_bit,
  output logic pulse_n
);
  localparam int unsigned MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
  localparam int unsigned CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CW-1:0] DLY_LOAD = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] PLS_LOAD = CW'(PULSE_CYC - 1);

  tmr_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      TMR_IDLE: begin
        if (req_bit) begin
          state_d = TMR_DELAY;
          cnt_d   = DLY_LOAD;
        end
      end
      TMR_DELAY: begin
        if (cnt_zero) begin
          state_d = TMR_PULSE;
          cnt_d   = PLS_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      TMR_PULSE: begin
        if (cnt_zero) state_d = TMR_DONE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      TMR_DONE: begin
        if (!req_bit) state_d = TMR_IDLE;
      end
      default: state_d = TMR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pulse_n = (state_q != TMR_PULSE);
endmodule

// File: rtl/fg_out_merge.sv
module fg_out_merge (
  input  logic kbc_gate,
  input  logic gate_bit,
  input  logic kbc_rst_n,
  input  logic alt_rst_n,
  input  logic route_en,
  input  logic pol,
  output logic a20_mask,
  output logic cpu_rst
);
  logic alt_part_n, comb_n;

  assign a20_mask   = kbc_gate | gate_bit;
  assign alt_part_n = route_en ? alt_rst_n : 1'b1;
  assign comb_n     = kbc_rst_n & alt_part_n;
  assign cpu_rst    = pol ? ~comb_n : comb_n;
endmodule

// File: rtl/fastgate_ctrl.sv
module fastgate_ctrl
  import fg_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 33,
  parameter int unsigned DELAY_US = 14,
  parameter int unsigned PULSE_US = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             kbc_gate_i,
  input  logic             kbc_rst_n_i,
  input  logic             rst_route_en_i,
  input  logic             rst_pol_i,
  output logic             a20_mask_o,
  output logic             alt_rst_n_o,
  output logic             cpu_rst_o
);
  localparam int unsigned DELAY_CYC = DELAY_US * CLK_MHZ;
  localparam int unsigned PULSE_CYC = PULSE_US * CLK_MHZ;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       gate_bit, req_bit;
  logic       unused_wdata_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign unused_wdata_hi = ^bus_wdata[7:2];

  fg_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sel      (bus_sel),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .wdata_lo (bus_wdata[1:0]),
    .gate_bit (gate_bit),
    .req_bit  (req_bit),
    .rdata    (bus_rdata)
  );

  fg_pulse_timer #(
    .DELAY_CYC (DELAY_CYC),
    .PULSE_CYC (PULSE_CYC)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req_bit (req_bit),
    .pulse_n (alt_rst_n_o)
  );

  fg_out_merge u_merge (
    .kbc_gate  (kbc_gate_i),
    .gate_bit  (gate_bit),
    .kbc_rst_n (kbc_rst_n_i),
    .alt_rst_n (alt_rst_n_o),
    .route_en  (rst_route_en_i),
    .pol       (rst_pol_i),
    .a20_mask  (a20_mask_o),
    .cpu_rst   (cpu_rst_o)
  );
endmodule

// File: rtl/fastgate_ctrl_chk.sv
module fastgate_ctrl_chk #(
  parameter int unsigned PULSE_CYC = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       alt_rst_n,
  input logic       req_bit,
  input logic       kbc_gate,
  input logic       a20_mask,
  input logic       kbc_rst_n,
  input logic       rst_pol,
  input logic       cpu_rst,
  input logic [7:0] rdata
);
  logic [31:0] low_cnt_q;
  logic        armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      armed_q   <= 1'b1;
    end else begin
      low_cnt_q <= alt_rst_n ? 32'd0 : low_cnt_q + 32'd1;
      if (!req_bit)        armed_q <= 1'b1;
      else if (!alt_rst_n) armed_q <= 1'b0;
    end
  end

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alt_rst_n) |-> (low_cnt_q == PULSE_CYC));

  // R7
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alt_rst_n) |-> armed_q);

  // R9
  kbc_gate_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbc_gate |-> a20_mask);

  // R11
  kbc_reset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !kbc_rst_n |-> (cpu_rst == rst_pol));

  // R3
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7:2] == 6'b0);
endmodule

bind fastgate_ctrl fastgate_ctrl_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .alt_rst_n (alt_rst_n_o),
  .req_bit   (req_bit),
  .kbc_gate  (kbc_gate_i),
  .a20_mask  (a20_mask_o),
  .kbc_rst_n (kbc_rst_n_i),
  .rst_pol   (rst_pol_i),
  .cpu_rst   (cpu_rst_o),
  .rdata     (bus_rdata)
);

// File: tb/fastgate_ctrl_tb.sv
module fastgate_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 14;
  localparam int PLS = 6;
  localparam int WATCHDOG = 20000;

  // fields: [6]kbc_gate [5]gate bit [4]kbc_rst_n [3]route_en [2]pol [1]exp a20_mask [0]exp cpu_rst
  localparam logic [6:0] VEC [8] = '{
    7'b0011001, 7'b1011011, 7'b0110011, 7'b1101010,
    7'b0000101, 7'b0101111, 7'b1010110, 7'b0011100
  };

  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic kbc_gate_i, kbc_rst_n_i, rst_route_en_i, rst_pol_i;
  logic a20_mask_o, alt_rst_n_o, cpu_rst_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fastgate_ctrl #(.CLK_MHZ(1), .DELAY_US(DLY), .PULSE_US(PLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbc_gate_i(kbc_gate_i),
    .kbc_rst_n_i(kbc_rst_n_i), .rst_route_en_i(rst_route_en_i), .rst_pol_i(rst_pol_i),
    .a20_mask_o(a20_mask_o), .alt_rst_n_o(alt_rst_n_o), .cpu_rst_o(cpu_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic reg_rd(output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  // returns edges until fall and low width; samples at negedges
  task automatic measure(output int dly, output int wid, output logic cpu_in_pulse);
    dly = 0; wid = 0; cpu_in_pulse = 1'bx;
    for (int i = 0; i < 100 && alt_rst_n_o; i++) begin
      @(negedge clk); dly++;
    end
    cpu_in_pulse = cpu_rst_o;
    for (int i = 0; i < 100 && !alt_rst_n_o; i++) begin
      wid++; @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    while (cyc < WATCHDOG) begin
      @(posedge clk); cyc++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WATCHDOG);
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    int d, w;
    logic cp;
    logic seen_low;
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    kbc_gate_i = 0; kbc_rst_n_i = 1; rst_route_en_i = 1; rst_pol_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 alt_rst_n", alt_rst_n_o, 1);
    chk("R1 a20_mask", a20_mask_o, 0);
    reg_rd(rd);
    chk("R1 readback", rd, 8'h00);

    // R9 R10 R11 vector table (alternate reset idle)
    foreach (VEC[i]) begin
      kbc_gate_i = VEC[i][6]; kbc_rst_n_i = VEC[i][4];
      rst_route_en_i = VEC[i][3]; rst_pol_i = VEC[i][2];
      reg_wr(1'b1, {6'b0, VEC[i][5], 1'b0});
      #1;
      chk($sformatf("R9 vec%0d a20_mask", i), a20_mask_o, VEC[i][1]);
      chk($sformatf("R10/R11 vec%0d cpu_rst", i), cpu_rst_o, VEC[i][0]);
    end
    kbc_gate_i = 0; kbc_rst_n_i = 1; rst_route_en_i = 1; rst_pol_i = 0;

    // R2 R3 write/read of gate bit, upper bits ignored
    reg_wr(1'b1, 8'hFE);
    reg_rd(rd);
    chk("R2/R3 readback gate only", rd, 8'h02);
    #1 chk("R3 rdata idle zero", bus_rdata, 8'h00);
    chk("R2 a20 from gate bit", a20_mask_o, 1);

    // R4 unselected write ignored
    reg_wr(1'b0, 8'h00);
    reg_rd(rd);
    chk("R4 unselected write", rd, 8'h02);
    reg_wr(1'b1, 8'h00);
    #1 chk("R2 gate bit cleared", a20_mask_o, 0);

    // R5 R6 first pulse, route on, active-low
    reg_wr(1'b1, 8'h01);
    measure(d, w, cp);
    chk("R5 delay edges", d, DLY + 1);
    chk("R6 pulse width", w, PLS);
    chk("R10 cpu_rst low during pulse", cp, 0);
    reg_rd(rd);
    chk("R2 req bit held", rd, 8'h01);

    // R7 repeated write of 1: no pulse
    reg_wr(1'b1, 8'h01);
    seen_low = 1'b0;
    for (int i = 0; i < 3*(DLY+PLS); i++) begin
      @(negedge clk);
      if (!alt_rst_n_o) seen_low = 1'b1;
    end
    chk("R7 no second pulse", seen_low, 0);

    // R8 clear then set; route disabled
    reg_wr(1'b1, 8'h00);
    rst_route_en_i = 0;
    reg_wr(1'b1, 8'h01);
    measure(d, w, cp);
    chk("R8 re-armed delay", d, DLY + 1);
    chk("R8 re-armed width", w, PLS);
    chk("R10 masked while disabled", cp, 1);

    // R11 active-high polarity during pulse
    reg_wr(1'b1, 8'h00);
    rst_route_en_i = 1; rst_pol_i = 1;
    reg_wr(1'b1, 8'h01);
    measure(d, w, cp);
    chk("R11 active-high during pulse", cp, 1);
    chk("R11 inactive after pulse", cpu_rst_o, 0);

    // R1 system reset clears bits
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    reg_rd(rd);
    chk("R1 bits cleared by reset", rd, 8'h00);
    chk("R1 alt_rst_n high after reset", alt_rst_n_o, 1);

    finish_run();
  end
endmodule